// File: doc/BRIEF.md
# Multi-Block DMA Channel Sequencer

This block steps one DMA channel through a series of block transfers. Software programs a starting source address, a starting destination address and a block length. After a start strobe, the channel issues one source/destination address pair per beat through a valid/ready handshake. Each accepted beat moves both addresses forward by one transfer width.

When the final beat of a block has been issued, the channel waits for the destination side to report that this beat has been written. It then sets its block-complete status and decides what happens next. It may end the channel. It may stall until software clears the status. Or it may load the next block straight away. For the next block, each address is chosen on its own. It either continues from the end of the previous block, takes the value from a descriptor arriving on a valid/ready port, or falls back to its programmed initial value.

Without descriptors, the reload settings decide whether another block follows. Software can clear both reload settings during the last stall to make the next block the final one.

Top module: `dma_blk_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `ch_en`, `xfer_valid`, `xfer_done`, `blk_status`, `blk_irq` and `cfg_err` are all 0.
- R2: A start strobe in idle with both `cfg_src_cont` and `cfg_dst_cont` set leaves the channel idle (`ch_en` 0, no beats) and sets `cfg_err` from the next cycle. A start strobe with a legal setting clears `cfg_err`.
- R3: The first block's first beat carries `cfg_src_init` / `cfg_dst_init`. Each beat accepted with `xfer_valid && xfer_ready` advances both addresses by BEAT_BYTES. Addresses hold while a beat waits. A block has exactly length+1 beats, where the length comes from `cfg_blk_len` or `desc_len`.
- R4: `blk_status` rises only in the cycle after `wr_last_ack` arrives for a block whose last beat has been issued. It never rises on the beat itself. `blk_irq` equals `blk_status && cfg_int_en && !cfg_blk_mask`.
- R5: Without descriptors, when `cfg_int_en` is 1 and `cfg_blk_mask` is 0, a non-final block is followed by a stall. During the stall `ch_en` stays 1 and no beat is offered. A `blk_clr` pulse clears `blk_status` and lets the next block start.
- R6: Without descriptors, when interrupts are disabled or masked, the next block's first beat is offered two cycles after the `wr_last_ack` cycle, with no `blk_clr` needed.
- R7: At each block boundary each address is chosen separately. With its contiguous setting, it becomes the last beat's address plus BEAT_BYTES. Otherwise, in descriptor mode it takes the descriptor value, and outside descriptor mode it takes the initial value.
- R8: In descriptor mode (`cfg_desc_en` = 1) the channel never stalls. It raises `desc_ready` after each non-final block and starts the next block on the `desc_valid` handshake, taking its length from `desc_len`. A descriptor with `desc_last` = 1 makes that block the final one.
- R9: Without descriptors, a block is final when both `cfg_src_rld` and `cfg_dst_rld` are 0 at the moment it is loaded, whether at start or after a stall. After a final block's `wr_last_ack`, `xfer_done` is 1 for exactly one cycle and `ch_en` is 0 from that cycle onward.
- R10: `ch_disable` returns the channel to idle. From the next cycle `ch_en` and `xfer_valid` are 0, and no `xfer_done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_start | input | 1 | Start strobe, taken only in idle |
| ch_disable | input | 1 | Abort to idle |
| cfg_src_init | input | AW | Programmed initial source address |
| cfg_dst_init | input | AW | Programmed initial destination address |
| cfg_blk_len | input | CW | Beats per block minus one |
| cfg_src_cont | input | 1 | Source continues across block boundaries |
| cfg_dst_cont | input | 1 | Destination continues across block boundaries |
| cfg_src_rld | input | 1 | Source reload setting; keeps chain going without descriptors |
| cfg_dst_rld | input | 1 | Destination reload setting; keeps chain going without descriptors |
| cfg_desc_en | input | 1 | Next blocks come from the descriptor port |
| cfg_int_en | input | 1 | Channel interrupt enable |
| cfg_blk_mask | input | 1 | Block interrupt mask (1 = masked) |
| blk_clr | input | 1 | Software clear-block strobe |
| desc_valid | input | 1 | Descriptor present |
| desc_ready | output | 1 | Channel takes a descriptor |
| desc_src | input | AW | Descriptor source address |
| desc_dst | input | AW | Descriptor destination address |
| desc_len | input | CW | Descriptor beats minus one |
| desc_last | input | 1 | Descriptor block is the final one |
| xfer_valid | output | 1 | Beat address pair offered |
| xfer_ready | input | 1 | Beat accepted |
| xfer_src | output | AW | Beat source address |
| xfer_dst | output | AW | Beat destination address |
| wr_last_ack | input | 1 | Destination has written the block's last beat |
| blk_status | output | 1 | Block-complete status |
| blk_irq | output | 1 | Block-complete interrupt |
| cfg_err | output | 1 | Last start refused for an illegal setting |
| ch_en | output | 1 | Channel active |
| xfer_done | output | 1 | One-cycle pulse at channel end |

## Verification
The bench builds the block with AW = 16, CW = 4 and BEAT_BYTES = 4. Blocks of 1 to 16 beats therefore keep chains short enough to run dozens of random multi-block chains. Random source and destination starts make 16-bit address wrap across block ends reachable. The narrow length field also makes the shortest block, a single beat where first beat and last beat coincide, a frequent case.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_XFER    = 3'd1,
    ST_BLK_END = 3'd2,
    ST_STALL   = 3'd3,
    ST_LOAD    = 3'd4,
    ST_DONE    = 3'd5
  } dbs_state_e;

  typedef enum logic [1:0] {
    NXT_CONT = 2'd0,
    NXT_DESC = 2'd1,
    NXT_INIT = 2'd2
  } nxt_sel_e;

  // source of an address for the block that follows a boundary
  function automatic nxt_sel_e pick_next(input logic cont, input logic desc_mode);
    if (cont)           return NXT_CONT;
    else if (desc_mode) return NXT_DESC;
    else                return NXT_INIT;
  endfunction

  // a chain without descriptors goes on while either reload setting is set
  function automatic logic chain_ends(input logic src_rld, input logic dst_rld);
    return !(src_rld || dst_rld);
  endfunction

endpackage

// File: rtl/dbs_addr_lane.sv
module dbs_addr_lane
  import dbs_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_first,
  input  logic          ld_next,
  input  logic          beat,
  input  logic          cont,
  input  logic          desc_mode,
  input  logic [AW-1:0] init_a,
  input  logic [AW-1:0] desc_a,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  function automatic logic [AW-1:0] next_base(input nxt_sel_e sel,
                                              input logic [AW-1:0] end_a,
                                              input logic [AW-1:0] ini,
                                              input logic [AW-1:0] dsc);
    case (sel)
      NXT_CONT: return end_a;
      NXT_DESC: return dsc;
      default:  return ini;
    endcase
  endfunction

  nxt_sel_e sel;
  assign sel = pick_next(cont, desc_mode);

  always_ff @(posedge clk) begin
    if (!rst_n)        addr <= '0;
    else if (ld_first) addr <= init_a;
    else if (ld_next)  addr <= next_base(sel, addr, init_a, desc_a);
    else if (beat)     addr <= addr + STEP_V;
  end

  AST_LANE_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_next && cont && !ld_first) |=> addr == $past(addr)); // R7

  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && !ld_first && !ld_next) |=> $stable(addr)); // R3

endmodule

// File: rtl/dbs_beat_ctr.sv
module dbs_beat_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  input  logic          beat,
  output logic          last
);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)                   remain <= '0;
    else if (load)                remain <= len;
    else if (beat && remain != 0) remain <= remain - 1'b1;
  end

  assign last = (remain == '0);

  AST_CTR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !load && last) |=> last); // R3

endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
  import dbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic       bad_cfg,
  input  logic       beat,
  input  logic       beat_last,
  input  logic       wr_last_ack,
  input  logic       desc_mode,
  input  logic       stall_req,
  input  logic       desc_valid,
  input  logic       blk_clr,
  input  logic       src_rld,
  input  logic       dst_rld,
  input  logic       desc_last,
  output dbs_state_e state,
  output logic       ld_first,
  output logic       ld_next,
  output logic       blk_set
);

  dbs_state_e nxt;
  logic       final_blk;

  assign ld_first = (state == ST_IDLE) && start && !bad_cfg && !abort;
  assign ld_next  = (state == ST_LOAD) && (!desc_mode || desc_valid) && !abort;
  assign blk_set  = (state == ST_BLK_END) && wr_last_ack;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:    if (ld_first) nxt = ST_XFER;
      ST_XFER:    if (beat && beat_last) nxt = ST_BLK_END;
      ST_BLK_END: if (wr_last_ack) begin
                    if (final_blk)      nxt = ST_DONE;
                    else if (stall_req) nxt = ST_STALL;
                    else                nxt = ST_LOAD;
                  end
      ST_STALL:   if (blk_clr) nxt = ST_LOAD;
      ST_LOAD:    if (ld_next) nxt = ST_XFER;
      ST_DONE:    nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
    if (abort) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      final_blk <= 1'b0;
    end else begin
      state <= nxt;
      if (ld_first)
        final_blk <= !desc_mode && chain_ends(src_rld, dst_rld);
      else if (ld_next)
        final_blk <= desc_mode ? desc_last : chain_ends(src_rld, dst_rld);
    end
  end

  AST_CTRL_END_WAITS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BLK_END && !wr_last_ack && !abort) |=> state == ST_BLK_END); // R4

endmodule

// File: rtl/dma_blk_seq.sv
module dma_blk_seq
  import dbs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 8,
  parameter int BEAT_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ch_start,
  input  logic          ch_disable,
  input  logic [AW-1:0] cfg_src_init,
  input  logic [AW-1:0] cfg_dst_init,
  input  logic [CW-1:0] cfg_blk_len,
  input  logic          cfg_src_cont,
  input  logic          cfg_dst_cont,
  input  logic          cfg_src_rld,
  input  logic          cfg_dst_rld,
  input  logic          cfg_desc_en,
  input  logic          cfg_int_en,
  input  logic          cfg_blk_mask,
  input  logic          blk_clr,
  input  logic          desc_valid,
  output logic          desc_ready,
  input  logic [AW-1:0] desc_src,
  input  logic [AW-1:0] desc_dst,
  input  logic [CW-1:0] desc_len,
  input  logic          desc_last,
  output logic          xfer_valid,
  input  logic          xfer_ready,
  output logic [AW-1:0] xfer_src,
  output logic [AW-1:0] xfer_dst,
  input  logic          wr_last_ack,
  output logic          blk_status,
  output logic          blk_irq,
  output logic          cfg_err,
  output logic          ch_en,
  output logic          xfer_done
);

  localparam int LANES = 2;

  dbs_state_e    state;
  logic          ld_first, ld_next, blk_set;
  logic          beat, beat_last, bad_cfg, stall_req, stall_now;
  logic [CW-1:0] len_sel;
  logic [AW-1:0] lane_init [LANES];
  logic [AW-1:0] lane_desc [LANES];
  logic [AW-1:0] lane_addr [LANES];
  logic          lane_cont [LANES];

  assign xfer_valid = (state == ST_XFER);
  assign beat       = xfer_valid && xfer_ready;
  assign bad_cfg    = cfg_src_cont && cfg_dst_cont;
  assign stall_req  = !cfg_desc_en && cfg_int_en && !cfg_blk_mask;
  assign stall_now  = (state == ST_STALL);
  assign desc_ready = (state == ST_LOAD) && cfg_desc_en;
  assign len_sel    = (ld_next && cfg_desc_en) ? desc_len : cfg_blk_len;

  assign lane_init[0] = cfg_src_init;
  assign lane_init[1] = cfg_dst_init;
  assign lane_desc[0] = desc_src;
  assign lane_desc[1] = desc_dst;
  assign lane_cont[0] = cfg_src_cont;
  assign lane_cont[1] = cfg_dst_cont;

  dbs_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (ch_start),
    .abort       (ch_disable),
    .bad_cfg     (bad_cfg),
    .beat        (beat),
    .beat_last   (beat_last),
    .wr_last_ack (wr_last_ack),
    .desc_mode   (cfg_desc_en),
    .stall_req   (stall_req),
    .desc_valid  (desc_valid),
    .blk_clr     (blk_clr),
    .src_rld     (cfg_src_rld),
    .dst_rld     (cfg_dst_rld),
    .desc_last   (desc_last),
    .state       (state),
    .ld_first    (ld_first),
    .ld_next     (ld_next),
    .blk_set     (blk_set)
  );

  dbs_beat_ctr #(.CW(CW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ld_first || ld_next),
    .len   (len_sel),
    .beat  (beat),
    .last  (beat_last)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dbs_addr_lane #(.AW(AW), .STEP(BEAT_BYTES)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_first  (ld_first),
      .ld_next   (ld_next),
      .beat      (beat),
      .cont      (lane_cont[g]),
      .desc_mode (cfg_desc_en),
      .init_a    (lane_init[g]),
      .desc_a    (lane_desc[g]),
      .addr      (lane_addr[g])
    );
  end

  assign xfer_src = lane_addr[0];
  assign xfer_dst = lane_addr[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_status <= 1'b0;
      cfg_err    <= 1'b0;
    end else begin
      if (blk_set)      blk_status <= 1'b1;
      else if (blk_clr) blk_status <= 1'b0;
      if (state == ST_IDLE && ch_start && !ch_disable) cfg_err <= bad_cfg;
    end
  end

  assign blk_irq   = blk_status && cfg_int_en && !cfg_blk_mask;
  assign ch_en     = (state == ST_XFER) || (state == ST_BLK_END) ||
                     (state == ST_STALL) || (state == ST_LOAD);
  assign xfer_done = (state == ST_DONE);

  AST_BAD_CFG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start && bad_cfg && !ch_en && !xfer_done && !ch_disable) |=> (!ch_en && cfg_err)); // R2

  AST_STAT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_status) |-> $past(wr_last_ack)); // R4

  AST_STALL_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_now && !blk_clr && !ch_disable) |=> (!xfer_valid && ch_en)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R9

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ch_disable |=> (!ch_en && !xfer_valid && !xfer_done)); // R10

endmodule

// File: tb/dma_blk_seq_tb_top.sv
module dma_blk_seq_tb_top;
  localparam int AW = 16;
  localparam int CW = 4;
  localparam int BB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          ch_start = 0, ch_disable = 0;
  logic [AW-1:0] cfg_src_init = 0, cfg_dst_init = 0;
  logic [CW-1:0] cfg_blk_len = 0;
  logic          cfg_src_cont = 0, cfg_dst_cont = 0, cfg_src_rld = 0, cfg_dst_rld = 0;
  logic          cfg_desc_en = 0, cfg_int_en = 0, cfg_blk_mask = 0, blk_clr = 0;
  logic          desc_valid = 0, desc_last = 0;
  logic [AW-1:0] desc_src = 0, desc_dst = 0;
  logic [CW-1:0] desc_len = 0;
  logic          xfer_ready = 0, wr_last_ack = 0;
  logic          desc_ready, xfer_valid, blk_status, blk_irq, cfg_err, ch_en, xfer_done;
  logic [AW-1:0] xfer_src, xfer_dst;

  int nvec = 0;
  int nfail = 0;

  dma_blk_seq #(.AW(AW), .CW(CW), .BEAT_BYTES(BB)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_start(ch_start), .ch_disable(ch_disable),
    .cfg_src_init(cfg_src_init), .cfg_dst_init(cfg_dst_init), .cfg_blk_len(cfg_blk_len),
    .cfg_src_cont(cfg_src_cont), .cfg_dst_cont(cfg_dst_cont),
    .cfg_src_rld(cfg_src_rld), .cfg_dst_rld(cfg_dst_rld), .cfg_desc_en(cfg_desc_en),
    .cfg_int_en(cfg_int_en), .cfg_blk_mask(cfg_blk_mask), .blk_clr(blk_clr),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_src(desc_src),
    .desc_dst(desc_dst), .desc_len(desc_len), .desc_last(desc_last),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_src(xfer_src),
    .xfer_dst(xfer_dst), .wr_last_ack(wr_last_ack), .blk_status(blk_status),
    .blk_irq(blk_irq), .cfg_err(cfg_err), .ch_en(ch_en), .xfer_done(xfer_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // address for the block after a boundary, restated from R7
  function automatic logic [AW-1:0] exp_next(input bit cont, input bit dmode,
      input logic [AW-1:0] end_a, input logic [AW-1:0] ini, input logic [AW-1:0] d);
    logic [AW-1:0] r;
    r = dmode ? d : ini;
    if (cont) r = end_a;
    return r;
  endfunction

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base, input int k);
    return base + AW'(k * BB);
  endfunction

  task automatic consume(input logic [AW-1:0] s0, input logic [AW-1:0] d0,
                         input int nb, input string req);
    int k = 0;
    while (k < nb) begin
      @(negedge clk);
      if (xfer_valid) begin
        desc_valid = 0;
        chk(xfer_src == beat_addr(s0, k), req, "beat src", xfer_src, beat_addr(s0, k));
        chk(xfer_dst == beat_addr(d0, k), req, "beat dst", xfer_dst, beat_addr(d0, k));
      end
      xfer_ready = ($urandom % 3) != 0;
      if (xfer_valid && xfer_ready) k++;
    end
    @(negedge clk);
    xfer_ready = 0;
    chk(!xfer_valid, "R3", "valid after last beat", xfer_valid, 0);
    chk(!blk_status, "R4", "status before ack", blk_status, 0);
  endtask

  task automatic run_chain(input bit dm, input bit sc, input bit dc, input bit ie,
                           input bit mk, input int nblk);
    logic [AW-1:0] cs, cd, ns, nd, end_s, end_d;
    logic [CW-1:0] cl, nl;
    bit stall;
    cfg_desc_en = dm; cfg_src_cont = sc; cfg_dst_cont = dc;
    cfg_int_en = ie; cfg_blk_mask = mk;
    cfg_src_init = AW'($urandom); cfg_dst_init = AW'($urandom);
    cfg_blk_len = CW'($urandom);
    cfg_src_rld = (nblk > 1); cfg_dst_rld = (nblk > 1) && ($urandom % 2);
    @(negedge clk); ch_start = 1;
    @(negedge clk); ch_start = 0;
    chk(ch_en && !cfg_err, "R2", "legal start runs", {ch_en, cfg_err}, 2'b10);
    cs = cfg_src_init; cd = cfg_dst_init; cl = cfg_blk_len;
    for (int b = 0; b < nblk; b++) begin
      consume(cs, cd, int'(cl) + 1, (b == 0) ? "R3" : "R7");
      end_s = beat_addr(cs, int'(cl) + 1);
      end_d = beat_addr(cd, int'(cl) + 1);
      ns = AW'($urandom); nd = AW'($urandom); nl = CW'($urandom);
      if (dm && b < nblk - 1) begin
        desc_src = ns; desc_dst = nd; desc_len = nl;
        desc_last = (b + 1 == nblk - 1); desc_valid = 1;
      end
      if (!dm && b + 1 == nblk - 1) begin cfg_src_rld = 0; cfg_dst_rld = 0; end
      wr_last_ack = 1;
      @(negedge clk); wr_last_ack = 0;
      chk(blk_status, "R4", "status after ack", blk_status, 1);
      chk(blk_irq == (ie && !mk), "R4", "irq gating", blk_irq, ie && !mk);
      if (b == nblk - 1) begin
        chk(xfer_done && !ch_en, "R9", "done pulse", {xfer_done, ch_en}, 2'b10);
        blk_clr = 1;
        @(negedge clk); blk_clr = 0;
        chk(!xfer_done, "R9", "done one cycle", xfer_done, 0);
        chk(!blk_status, "R5", "clear status", blk_status, 0);
      end else begin
        stall = !dm && ie && !mk;
        if (stall) begin
          for (int i = 0; i < 3; i++) begin
            chk(!xfer_valid && ch_en, "R5", "stalled", {xfer_valid, ch_en}, 2'b01);
            @(negedge clk);
          end
          blk_clr = 1;
          @(negedge clk); blk_clr = 0;
          chk(!blk_status, "R5", "clear status", blk_status, 0);
        end else begin
          if (dm) chk(desc_ready, "R8", "desc ready", desc_ready, 1);
          blk_clr = 1;
          @(negedge clk); blk_clr = 0;
          chk(xfer_valid, dm ? "R8" : "R6", "next block without stall", xfer_valid, 1);
        end
        cs = exp_next(sc, dm, end_s, cfg_src_init, ns);
        cd = exp_next(dc, dm, end_d, cfg_dst_init, nd);
        cl = dm ? nl : cfg_blk_len;
      end
    end
    desc_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5eed));
    repeat (3) @(negedge clk);
    chk({ch_en, xfer_valid, xfer_done, blk_status, blk_irq, cfg_err} == 0, "R1",
        "outputs in reset", {ch_en, xfer_valid, xfer_done, blk_status, blk_irq, cfg_err}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({ch_en, xfer_valid, xfer_done, blk_status, blk_irq, cfg_err} == 0, "R1",
        "outputs after reset", {ch_en, xfer_valid, xfer_done, blk_status, blk_irq, cfg_err}, 0);

    // R2: illegal setting refused
    cfg_src_cont = 1; cfg_dst_cont = 1; cfg_src_rld = 1;
    ch_start = 1;
    @(negedge clk); ch_start = 0;
    chk(cfg_err && !ch_en && !xfer_valid, "R2", "illegal start",
        {cfg_err, ch_en, xfer_valid}, 3'b100);
    repeat (3) @(negedge clk);
    chk(!ch_en && !xfer_valid, "R2", "stays idle", {ch_en, xfer_valid}, 0);

    // directed chains
    run_chain(0, 1, 0, 1, 0, 3);   // R5 stall, R7 source continue
    run_chain(0, 0, 1, 1, 1, 3);   // R6 masked
    run_chain(0, 0, 0, 0, 0, 2);   // R6 disabled
    run_chain(0, 0, 0, 1, 0, 1);   // R9 single block
    run_chain(1, 0, 1, 1, 0, 4);   // R8 no stall with irq live

    // R10: abort mid block
    cfg_desc_en = 0; cfg_src_cont = 0; cfg_dst_cont = 0; cfg_blk_len = '1;
    cfg_src_rld = 1;
    @(negedge clk); ch_start = 1;
    @(negedge clk); ch_start = 0;
    chk(xfer_valid, "R10", "running before abort", xfer_valid, 1);
    ch_disable = 1;
    @(negedge clk); ch_disable = 0;
    chk(!ch_en && !xfer_valid, "R10", "aborted", {ch_en, xfer_valid}, 0);
    for (int i = 0; i < 3; i++) begin
      chk(!xfer_done && !ch_en, "R10", "no done after abort", {xfer_done, ch_en}, 0);
      @(negedge clk);
    end

    // random chains
    for (int n = 0; n < 30; n++) begin
      bit dm, sc, dc;
      int nb;
      dm = $urandom % 2;
      sc = $urandom % 2;
      dc = sc ? 1'b0 : 1'($urandom % 2);
      nb = dm ? 2 + int'($urandom % 3) : 1 + int'($urandom % 4);
      run_chain(dm, sc, dc, 1'($urandom % 2), 1'($urandom % 2), nb);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule